// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models the command side of an asynchronous parallel NOR flash as synchronous logic. A host drives a 16-bit data bus, an address bus, and active-low chip-enable, output-enable and write-enable strobes. Bus writes carry commands, and the block decodes them to program words, erase blocks, change the page configuration, and pick whether reads return array data or the status word. The storage is a small array of 16-bit words split into equal erase blocks.

Reads are page-mode reads. The page is 4 words or 8 words long, chosen by one configuration bit. The first access to a page takes a long latency, and a later access that stays inside the same open page takes a short one. A valid flag marks when the driven word can be used.

Setting the configuration takes two writes. The new value comes on the address bus, not on the data bus. A program write can only clear bits. The decoder has no inputs or state beyond what the command set needs.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the block is in read-array mode with a 4-word page. The status word reads 0x0080, every array word reads 0xFFFF, and the outputs are not driven.
- R2: `dq_drive` is high only while `ce_n` and `oe_n` are both low. While it is low, `dq_out` is 0x0000 and `dq_valid` is low.
- R3: Writing 0x0060 and then 0x0004 loads the configuration from the address bus of the second write. Only address bit 13 is kept, so every other address bit has no effect on page behaviour.
- R4: Configuration bit 13 = 1 selects an 8-word page, with the page chosen by address bits above bit 2. Bit 13 = 0 selects a 4-word page, with the page chosen by address bits above bit 1.
- R5: After the configuration is set to 8-word pages, the first array read access before a 0x0050 write sets status bit 3 (page-order error). Reads after the 0x0050 write do not set it.
- R6: The write 0x0040 followed by an (address, data) write stores old AND data at that word.
- R7: The writes 0x0020 and then 0x00D0 set every word of the 16-word block that holds the address to 0xFFFF. Words in other blocks keep their values.
- R8: If the second write of an erase or configuration sequence has the wrong code, the block returns to read-array mode and sets status bit 4 (sequence error).
- R9: Command codes: 0x0070 selects status reads, 0x00FF selects array reads, and 0x0050 clears status bits 4 and 3. The status word is {8'h00, ready, 2'b00, seq_err, page_err, 3'b000}.
- R10: After the write that starts a program or erase, the ready bit (status bit 7) is low for BUSY_CYCLES clocks and the block switches to status reads. While ready is low, every command except 0x0070 is ignored.
- R11: An access starts when a read begins or the address changes during a read. `dq_valid` rises FIRST_LAT+1 clocks after the start of an access to a new page, and PAGE_LAT+1 clocks after the start of an access inside the open page.
- R12: A write is taken on the clock where `we_n` is first seen high after being low, and only if `ce_n` is low then. Pulses on `we_n` with `ce_n` high have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; the rising edge captures a write |
| addr | input | AW | Word address; also carries the configuration value |
| dq_in | input | 16 | Write data / command code |
| dq_out | output | 16 | Read data (status or array word) |
| dq_drive | output | 1 | High when the data bus is driven; low means high-impedance |
| dq_valid | output | 1 | Read data has met its access latency |

## Verification
The assertions assume that a write pulse never overlaps an active read. `oe_n` is therefore high whenever `we_n` rises with `ce_n` low, so an access start and a captured command never fall on the same clock. They also assume that PAGE_LAT is at least 1, and that AW is at least 14 so that the page-select bit exists. The stimulus keeps to these rules: each write raises `oe_n` first, drives the strobes on the falling clock edge, and holds address and data steady for the whole write pulse.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam logic [15:0] OP_READ_ARRAY  = 16'h00FF;
    localparam logic [15:0] OP_READ_STATUS = 16'h0070;
    localparam logic [15:0] OP_CLEAR_STS   = 16'h0050;
    localparam logic [15:0] OP_PROGRAM     = 16'h0040;
    localparam logic [15:0] OP_ERASE       = 16'h0020;
    localparam logic [15:0] OP_ERASE_GO    = 16'h00D0;
    localparam logic [15:0] OP_CONFIG      = 16'h0060;
    localparam logic [15:0] OP_CONFIG_GO   = 16'h0004;

    localparam int CFG_PAGE_BIT = 13;
    localparam int PAGE4_SHIFT  = 2;
    localparam int PAGE8_SHIFT  = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_PROG,
        SEQ_ERASE,
        SEQ_CFG
    } seq_t;

    typedef struct packed {
        logic ready;
        logic seq_err;
        logic page_err;
    } status_t;

    function automatic logic [15:0] pack_status(status_t s);
        return {8'h00, s.ready, 2'b00, s.seq_err, s.page_err, 3'b000};
    endfunction

endpackage

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [15:0] wr_data,
    input  logic        cfg_bit,
    input  logic        access_start,
    output logic        prog_en,
    output logic        erase_en,
    output logic        show_status,
    output logic        page8,
    output status_t     sts
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    seq_t          seq;
    logic [BW-1:0] busy;
    logic          need_clear;
    logic          seq_err;
    logic          page_err;
    logic          idle_ok;

    assign idle_ok  = (busy == '0);
    assign prog_en  = wr_stb && idle_ok && (seq == SEQ_PROG);
    assign erase_en = wr_stb && idle_ok && (seq == SEQ_ERASE) && (wr_data == OP_ERASE_GO);
    assign sts      = '{ready: idle_ok, seq_err: seq_err, page_err: page_err};

    always_ff @(posedge clk) begin
        if (rst) begin
            seq         <= SEQ_IDLE;
            busy        <= '0;
            need_clear  <= 1'b0;
            seq_err     <= 1'b0;
            page_err    <= 1'b0;
            show_status <= 1'b0;
            page8       <= 1'b0;
        end else begin
            if (!idle_ok) busy <= busy - 1'b1;
            if (access_start && !show_status && page8 && need_clear) page_err <= 1'b1;
            if (wr_stb) begin
                if (!idle_ok) begin
                    if (wr_data == OP_READ_STATUS) show_status <= 1'b1;
                end else begin
                    unique case (seq)
                        SEQ_IDLE: begin
                            case (wr_data)
                                OP_READ_ARRAY:  show_status <= 1'b0;
                                OP_READ_STATUS: show_status <= 1'b1;
                                OP_CLEAR_STS: begin
                                    seq_err    <= 1'b0;
                                    page_err   <= 1'b0;
                                    need_clear <= 1'b0;
                                end
                                OP_PROGRAM:     seq <= SEQ_PROG;
                                OP_ERASE:       seq <= SEQ_ERASE;
                                OP_CONFIG:      seq <= SEQ_CFG;
                                default: ;
                            endcase
                        end
                        SEQ_PROG: begin
                            seq         <= SEQ_IDLE;
                            busy        <= BW'(BUSY_CYCLES);
                            show_status <= 1'b1;
                        end
                        SEQ_ERASE: begin
                            seq <= SEQ_IDLE;
                            if (wr_data == OP_ERASE_GO) begin
                                busy        <= BW'(BUSY_CYCLES);
                                show_status <= 1'b1;
                            end else begin
                                seq_err     <= 1'b1;
                                show_status <= 1'b0;
                            end
                        end
                        SEQ_CFG: begin
                            seq <= SEQ_IDLE;
                            if (wr_data == OP_CONFIG_GO) begin
                                page8      <= cfg_bit;
                                need_clear <= cfg_bit;
                            end else begin
                                seq_err     <= 1'b1;
                                show_status <= 1'b0;
                            end
                        end
                        default: seq <= SEQ_IDLE;
                    endcase
                end
            end
        end
    end

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !idle_ok && wr_data != OP_READ_STATUS)
        |=> (seq == $past(seq) && page8 == $past(page8) && show_status == $past(show_status)));

    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (prog_en || erase_en) |=> (!sts.ready && show_status));

    assert_bad_second_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && idle_ok && seq == SEQ_CFG && wr_data != OP_CONFIG_GO)
        |=> (sts.seq_err && !show_status && seq == SEQ_IDLE));

endmodule

// File: rtl/fcd_array.sv
module fcd_array #(
    parameter int WORDS       = 64,
    parameter int BLOCK_WORDS = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       prog_en,
    input  logic                       erase_en,
    input  logic [$clog2(WORDS)-1:0]   wr_idx,
    input  logic [15:0]                wr_data,
    input  logic [$clog2(WORDS)-1:0]   rd_idx,
    output logic [15:0]                rd_word
);
    localparam int IDXW = $clog2(WORDS);
    localparam int BLKW = $clog2(BLOCK_WORDS);

    logic [15:0]     mem [WORDS];
    logic [15:0]     old_word;
    logic [IDXW-1:0] blk_base;
    logic [IDXW-1:0] blk_last;

    assign old_word = mem[wr_idx];
    assign rd_word  = mem[rd_idx];
    assign blk_base = {wr_idx[IDXW-1:BLKW], {BLKW{1'b0}}};
    assign blk_last = {wr_idx[IDXW-1:BLKW], {BLKW{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else if (prog_en) begin
            mem[wr_idx] <= old_word & wr_data;
        end else if (erase_en) begin
            for (int i = 0; i < WORDS; i++) begin
                if ((i / BLOCK_WORDS) == int'(wr_idx[IDXW-1:BLKW])) mem[i] <= '1;
            end
        end
    end

    assert_prog_and_R6: assert property (@(posedge clk) disable iff (rst)
        prog_en |=> (mem[$past(wr_idx)] == ($past(old_word) & $past(wr_data))));

    assert_erase_ends_R7: assert property (@(posedge clk) disable iff (rst)
        (erase_en && !prog_en) |=> (mem[$past(blk_base)] == 16'hFFFF && mem[$past(blk_last)] == 16'hFFFF));

endmodule

// File: rtl/fcd_read_path.sv
module fcd_read_path
    import nor_cmd_pkg::*;
#(
    parameter int AW        = 16,
    parameter int FIRST_LAT = 4,
    parameter int PAGE_LAT  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          page8,
    input  logic          show_status,
    input  logic [15:0]   array_word,
    input  logic [15:0]   status_word,
    output logic          access_start,
    output logic [15:0]   dq_out,
    output logic          dq_drive,
    output logic          dq_valid
);
    localparam int LW = $clog2(FIRST_LAT + 1);

    logic          reading, reading_q;
    logic [AW-1:0] addr_q, tag, tag_q;
    logic          open_q, hit;
    logic [LW-1:0] cnt;

    assign reading      = !ce_n && !oe_n;
    assign access_start = reading && (!reading_q || addr != addr_q);
    assign tag          = page8 ? (addr >> PAGE8_SHIFT) : (addr >> PAGE4_SHIFT);
    assign hit          = open_q && (tag == tag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            reading_q <= 1'b0;
            addr_q    <= '0;
            tag_q     <= '0;
            open_q    <= 1'b0;
            cnt       <= '0;
        end else begin
            reading_q <= reading;
            addr_q    <= addr;
            if (access_start) begin
                cnt    <= hit ? LW'(PAGE_LAT) : LW'(FIRST_LAT);
                open_q <= 1'b1;
                tag_q  <= tag;
            end else begin
                if (cnt != '0) cnt <= cnt - 1'b1;
                if (!reading) open_q <= 1'b0;
            end
        end
    end

    assign dq_drive = reading;
    assign dq_valid = reading && !access_start && (cnt == '0);
    assign dq_out   = !reading ? 16'h0000 : (show_status ? status_word : array_word);

    assert_no_early_data_R11: assert property (@(posedge clk) disable iff (rst)
        access_start |=> !dq_valid);

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int AW          = 16,
    parameter int WORDS       = 64,
    parameter int BLOCK_WORDS = 16,
    parameter int BUSY_CYCLES = 12,
    parameter int FIRST_LAT   = 4,
    parameter int PAGE_LAT    = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic          dq_drive,
    output logic          dq_valid
);
    localparam int IDXW = $clog2(WORDS);

    logic        we_q;
    logic        wr_stb;
    logic        prog_en, erase_en, show_status, page8, access_start;
    status_t     sts;
    logic [15:0] array_word;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    assign wr_stb = !we_q && we_n && !ce_n;

    fcd_cmd_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk, .rst, .wr_stb,
        .wr_data      (dq_in),
        .cfg_bit      (addr[CFG_PAGE_BIT]),
        .access_start,
        .prog_en, .erase_en, .show_status, .page8, .sts
    );

    fcd_array #(.WORDS(WORDS), .BLOCK_WORDS(BLOCK_WORDS)) u_array (
        .clk, .rst, .prog_en, .erase_en,
        .wr_idx  (addr[IDXW-1:0]),
        .wr_data (dq_in),
        .rd_idx  (addr[IDXW-1:0]),
        .rd_word (array_word)
    );

    fcd_read_path #(.AW(AW), .FIRST_LAT(FIRST_LAT), .PAGE_LAT(PAGE_LAT)) u_read (
        .clk, .rst, .ce_n, .oe_n, .addr, .page8, .show_status,
        .array_word,
        .status_word (pack_status(sts)),
        .access_start, .dq_out, .dq_drive, .dq_valid
    );

    assert_hiz_R2: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> (!dq_drive && !dq_valid && dq_out == 16'h0000));

    assert_write_edge_R12: assert property (@(posedge clk) disable iff (rst)
        (ce_n && !prog_en) |=> $stable(page8));

endmodule

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;
    localparam int BUSY  = 12;
    localparam int FIRST = 4;
    localparam int PAGEL = 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [15:0] addr = '0, dq_in = '0;
    logic [15:0] dq_out;
    logic dq_drive, dq_valid;

    int tests = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    nor_cmd_decoder #(.AW(16), .WORDS(64), .BLOCK_WORDS(16), .BUSY_CYCLES(BUSY),
                      .FIRST_LAT(FIRST), .PAGE_LAT(PAGEL)) i_nor_cmd_decoder (
        .clk, .rst, .ce_n, .oe_n, .we_n, .addr, .dq_in, .dq_out, .dq_drive, .dq_valid);

    // behavioural reference model
    logic [15:0] m_mem [64];
    bit m_stat, m_page8, m_pclr, m_seq, m_perr, m_rdp, m_wep, m_open;
    int m_pend, m_busy, m_lat;
    logic [15:0] m_last, m_tag;

    always @(posedge clk) begin
        bit rd, rs, stb; int bb; logic [15:0] tg;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 16'hFFFF;
            m_stat = 0; m_page8 = 0; m_pclr = 0; m_seq = 0; m_perr = 0;
            m_rdp = 0; m_wep = 1; m_open = 0; m_pend = 0; m_busy = 0; m_lat = 0;
            m_last = 0; m_tag = 0;
        end else begin
            rd = !ce_n && !oe_n;
            rs = rd && (!m_rdp || addr != m_last);
            tg = m_page8 ? (addr >> 3) : (addr >> 2);
            if (rs && !m_stat && m_page8 && m_pclr) m_perr = 1;
            if (rs) begin
                m_lat = (m_open && tg == m_tag) ? PAGEL : FIRST;
                m_open = 1; m_tag = tg;
            end else begin
                if (m_lat > 0) m_lat--;
                if (!rd) m_open = 0;
            end
            bb = m_busy;
            if (m_busy > 0) m_busy--;
            stb = !m_wep && we_n && !ce_n;
            if (stb) begin
                if (bb > 0) begin
                    if (dq_in == 16'h0070) m_stat = 1;
                end else if (m_pend == 0) begin
                    case (dq_in)
                        16'h00FF: m_stat = 0;
                        16'h0070: m_stat = 1;
                        16'h0050: begin m_seq = 0; m_perr = 0; m_pclr = 0; end
                        16'h0040: m_pend = 1;
                        16'h0020: m_pend = 2;
                        16'h0060: m_pend = 3;
                        default: ;
                    endcase
                end else if (m_pend == 1) begin
                    m_mem[addr[5:0]] = m_mem[addr[5:0]] & dq_in;
                    m_busy = BUSY; m_stat = 1; m_pend = 0;
                end else if (m_pend == 2) begin
                    m_pend = 0;
                    if (dq_in == 16'h00D0) begin
                        for (int i = 0; i < 64; i++) if (i / 16 == int'(addr[5:4])) m_mem[i] = 16'hFFFF;
                        m_busy = BUSY; m_stat = 1;
                    end else begin m_seq = 1; m_stat = 0; end
                end else begin
                    m_pend = 0;
                    if (dq_in == 16'h0004) begin m_page8 = addr[13]; m_pclr = addr[13]; end
                    else begin m_seq = 1; m_stat = 0; end
                end
            end
            m_wep = we_n; m_rdp = rd; m_last = addr;
        end
    end

    // per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        bit rd, rs, ev; logic [15:0] eo;
        #1;
        if (!rst && !done) begin
            rd = !ce_n && !oe_n;
            rs = rd && (!m_rdp || addr != m_last);
            ev = rd && !rs && m_lat == 0;
            eo = !rd ? 16'h0 : (m_stat ? {8'h00, m_busy == 0, 2'b00, m_seq, m_perr, 3'b000}
                                       : m_mem[addr[5:0]]);
            tests++;
            if (dq_drive !== rd) begin fails++; $display("FAIL R2 dq_drive act=%b exp=%b", dq_drive, rd); end
            else if (dq_valid !== ev) begin fails++; $display("FAIL R11 dq_valid act=%b exp=%b", dq_valid, ev); end
            else if (dq_out !== eo) begin fails++; $display("FAIL R9 dq_out act=%h exp=%h", dq_out, eo); end
        end
    end

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [15:0] a, logic [15:0] d);
        @(negedge clk); oe_n = 1; ce_n = 0; we_n = 0; addr = a; dq_in = d;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic read_at(logic [15:0] a, output int lat, output logic [15:0] v);
        bit got;
        @(negedge clk); ce_n = 0; oe_n = 0; addr = a;
        lat = 0; v = 16'hxxxx; got = 0;
        for (int k = 0; k < 30 && !got; k++) begin
            @(posedge clk); #1;
            lat++;
            if (dq_valid) begin got = 1; v = dq_out; end
        end
    endtask

    task automatic end_read();
        @(negedge clk); oe_n = 1; ce_n = 1;
    endtask

    task automatic read_one(logic [15:0] a, output logic [15:0] v);
        int l;
        read_at(a, l, v);
        end_read();
    endtask

    task automatic wait_idle();
        repeat (BUSY + 4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v; int l;
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        check("R1 drive after reset", {15'b0, dq_drive}, 16'h0);
        check("R1 valid after reset", {15'b0, dq_valid}, 16'h0);
        read_one(16'h0000, v);  check("R1 erased word", v, 16'hFFFF);
        bus_write(0, 16'h0070);
        read_one(16'h0000, v);  check("R1 status after reset", v, 16'h0080);
        read_at(16'h0001, l, v); check("R11 first access latency", l[15:0], 16'(FIRST + 1));
        end_read();

        // program: AND semantics, busy and status switch
        bus_write(0, 16'h0040); bus_write(16'h0005, 16'h1234);
        read_one(16'h0005, v);  check("R10 ready low after program", v & 16'h0080, 16'h0000);
        wait_idle();
        bus_write(0, 16'h00FF);
        read_one(16'h0005, v);  check("R6 first program", v, 16'h1234);
        bus_write(0, 16'h0040); bus_write(16'h0005, 16'hFF00);
        wait_idle(); bus_write(0, 16'h00FF);
        read_one(16'h0005, v);  check("R6 program clears only", v, 16'h1200);

        // commands ignored while busy
        bus_write(0, 16'h0040); bus_write(16'h0006, 16'h00F0);
        bus_write(0, 16'h00FF);
        read_one(16'h0006, v);  check("R10 read-array ignored while busy", v & 16'hFF7F, 16'h0000);
        wait_idle();
        read_one(16'h0006, v);  check("R10 status ready again", v, 16'h0080);

        // erase block 1
        bus_write(0, 16'h0040); bus_write(16'h0010, 16'h0000); wait_idle();
        bus_write(0, 16'h0040); bus_write(16'h001F, 16'h0F0F); wait_idle();
        bus_write(0, 16'h0020); bus_write(16'h0015, 16'h00D0); wait_idle();
        bus_write(0, 16'h00FF);
        read_one(16'h0010, v);  check("R7 block first word", v, 16'hFFFF);
        read_one(16'h001F, v);  check("R7 block last word", v, 16'hFFFF);
        read_one(16'h0005, v);  check("R7 other block kept", v, 16'h1200);

        // wrong second code
        bus_write(0, 16'h0020); bus_write(16'h0005, 16'h0055);
        read_one(16'h0005, v);  check("R8 back to array mode", v, 16'h1200);
        bus_write(0, 16'h0070);
        read_one(0, v);         check("R8 sequence error bit", v, 16'h0090);
        bus_write(0, 16'h0050);
        read_one(0, v);         check("R9 clear status", v, 16'h0080);
        bus_write(0, 16'h0060); bus_write(16'h2000, 16'h00FF);
        bus_write(0, 16'h0070);
        read_one(0, v);         check("R8 config bad code", v, 16'h0090);
        bus_write(0, 16'h0050);

        // 8-word page with reserved bits also set on the address
        bus_write(0, 16'h0060); bus_write(16'hFFFF, 16'h0004);
        bus_write(0, 16'h00FF);
        read_at(16'h0020, l, v); check("R4 first access 8-word", l[15:0], 16'(FIRST + 1));
        read_at(16'h0024, l, v); check("R4 in-page 8-word", l[15:0], 16'(PAGEL + 1));
        check("R4 in-page data", v, 16'hFFFF);
        end_read();
        bus_write(0, 16'h0070);
        read_one(0, v);         check("R5 page-order error set", v, 16'h0088);
        bus_write(0, 16'h0050); bus_write(0, 16'h00FF);
        read_one(16'h0030, v);
        bus_write(0, 16'h0070);
        read_one(0, v);         check("R5 no error after clear", v, 16'h0080);

        // 4-word page, other address bits high
        bus_write(0, 16'h0060); bus_write(16'hDFFF, 16'h0004);
        bus_write(0, 16'h00FF);
        read_at(16'h0020, l, v);
        read_at(16'h0024, l, v); check("R3 reserved bits ignored", l[15:0], 16'(FIRST + 1));
        read_at(16'h0025, l, v); check("R11 in-page latency", l[15:0], 16'(PAGEL + 1));
        end_read();

        // write pulse without chip enable
        @(negedge clk); ce_n = 1; we_n = 0; dq_in = 16'h0070; addr = 16'h0005;
        @(negedge clk); we_n = 1;
        @(negedge clk);
        read_one(16'h0005, v);  check("R12 write ignored without ce", v, 16'h1200);

        repeat (4) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule